// File: doc/BRIEF.md
# Chainable Dual-Half Interval Timer

This block is a memory-mapped timer with two 16-bit halves, A and B. For the modes built here the halves act as one 32-bit timer. Software programs it through a synchronous register bus. The bus takes one write per clock on `bus_wr`, and read data depends on `bus_addr` alone, with no added latency.

Two joined modes are supported. In countdown mode (configuration 0) the 32-bit counter counts down once per clock. It runs either periodically or as a one-shot. Each expiry can raise an interrupt and can also emit a one-clock pulse that starts an ADC conversion. In calendar mode (configuration 1) the counter counts up on a once-per-second strobe, `sec_tick`, and flags an interrupt when it equals a programmed 32-bit match value. The load value and the match value are each kept as two 16-bit halves. Their upper half shows in the A-side reads only while the configuration is below 4, which is the joined range.

The interrupt line is a level signal. It is the OR of the raw event flags ANDed with a mask. The flags are cleared by writing ones to a clear register.

Top module: `gpt_top`

## Requirements
- R1: After reset every register reads 0, the counter is stopped, and `irq` and `adc_trig` are low.
- R2: With configuration 0 and enable bit 0 of the control register (offset 0x0C) rising, the counter (read at 0x48) loads {high half, low half} of the load value and then falls by one per clock. On the clock where it sits at 0, raw status bit 0 is set and, in periodic mode, the counter reloads, giving a period of load+1 clocks.
- R3: When bit 0 of the A mode register (offset 0x04) is 1, expiry stops the counter. The counter then holds the reloaded value and no further expiry occurs.
- R4: When control bit 5 is set, each expiry drives `adc_trig` high for the single clock that follows it.
- R5: The counter starts only on a change of control bit 0 from 0 to 1, and stops, frozen, on a change from 1 to 0. Rewriting the same value of bit 0 neither restarts nor stops it.
- R6: With configuration 1, starting clears the counter. Each clock with `sec_tick` high then adds one. When the new value equals {match high, match low}, raw status bit 3 is set. Clocks without `sec_tick` leave the counter unchanged.
- R7: The mask register at 0x18 keeps only bits 0x77 of a write. `irq` is high exactly when (raw at 0x1C AND mask) is non-zero, and offset 0x20 reads that AND.
- R8: Writing a 1 to a bit of the clear register at 0x24 clears that raw bit. An event on the same clock sets its bit anyway.
- R9: A write to 0x28 stores bits 15:0 in the load low half and bits 31:16 in the load high half. A write to 0x2C stores bits 15:0 in the high half. Reading 0x28 returns the high half in bits 31:16 only when the configuration (offset 0x00, 3 bits) is below 4. Reading 0x2C returns the high half.
- R10: A write to 0x30 stores both match halves in the same way as 0x28. A write to 0x34 stores bits 31:16 in the match high half. Reads of 0x30 and 0x34 follow the rule of R9.
- R11: The prescale registers (0x38 and 0x3C), the prescale-match registers (0x40 and 0x44) and the B mode register (0x08) are storage only. The first four keep 8 bits and the B mode register keeps 4. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sec_tick | input | 1 | Once-per-second strobe for calendar mode |
| irq | output | 1 | Masked interrupt level |
| adc_trig | output | 1 | One-clock ADC start pulse |

## Verification
A wrong counter value shows on the count read in the same clock. The timing of expiry then drifts, so `irq`, raw status and `adc_trig` go wrong within one period. A stale run flag shows at once, either as a counter that keeps moving after a stop or as a counter that stays frozen after a start. A wrong mask or raw flag shows directly on `irq` and on the masked status read. The bench reads the count or a status register on every clock, so any divergence is visible in the first clock after it happens.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int HALF_W = 16;
    localparam int CNT_W  = 2 * HALF_W;
    localparam int DATA_W = CNT_W;
    localparam int ADDR_W = 12;
    localparam int CFG_W  = 3;
    localparam int MODE_W = 4;
    localparam int CTL_W  = 16;
    localparam int IRQ_W  = 7;
    localparam int PRE_W  = 8;

    localparam logic [CFG_W-1:0] CFG_CHAIN     = 3'd0;
    localparam logic [CFG_W-1:0] CFG_RTC       = 3'd1;
    localparam logic [CFG_W-1:0] CFG_SPLIT_MIN = 3'd4;

    localparam int EN_A_BIT    = 0;
    localparam int TRIG_BIT    = 5;
    localparam int ONESHOT_BIT = 0;
    localparam int TO_BIT      = 0;
    localparam int RTC_BIT     = 3;
    localparam logic [IRQ_W-1:0] MASK_KEEP = 7'h77;

    // register indices; offsets are computed by reg_off
    localparam int RI_CFG     = 0;
    localparam int RI_MODE_A  = 1;
    localparam int RI_MODE_B  = 2;
    localparam int RI_CTL     = 3;
    localparam int RI_MASK    = 4;
    localparam int RI_RAW     = 5;
    localparam int RI_MIS     = 6;
    localparam int RI_CLR     = 7;
    localparam int RI_LOAD_A  = 8;
    localparam int RI_LOAD_B  = 9;
    localparam int RI_MATCH_A = 10;
    localparam int RI_MATCH_B = 11;
    localparam int RI_PRE_A   = 12;
    localparam int RI_PRE_B   = 13;
    localparam int RI_PMAT_A  = 14;
    localparam int RI_PMAT_B  = 15;
    localparam int RI_COUNT   = 16;
    localparam int NREG       = 17;

    // word spacing, with a two-word hole after the control register
    function automatic logic [ADDR_W-1:0] reg_off(input int idx);
        return (idx < RI_MASK) ? ADDR_W'(idx * 4) : ADDR_W'(idx * 4 + 8);
    endfunction

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [MODE_W-1:0] mode_a;
        logic [MODE_W-1:0] mode_b;
        logic [CTL_W-1:0]  ctl;
        logic [IRQ_W-1:0]  mask;
        logic [IRQ_W-1:0]  raw;
        logic [HALF_W-1:0] load_lo;
        logic [HALF_W-1:0] load_hi;
        logic [HALF_W-1:0] match_lo;
        logic [HALF_W-1:0] match_hi;
        logic [PRE_W-1:0]  pre_a;
        logic [PRE_W-1:0]  pre_b;
        logic [PRE_W-1:0]  pmat_a;
        logic [PRE_W-1:0]  pmat_b;
        logic [CNT_W-1:0]  cnt;
        logic              run;
        logic              trig;
    } gpt_state_t;
endpackage

// File: rtl/gpt_wdec.sv
module gpt_wdec
    import gpt_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   hit,
    output logic [NREG-1:0]   wstb
);
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign hit[i]  = (addr == reg_off(i));
        assign wstb[i] = wr & hit[i];
    end
endmodule

// File: rtl/gpt_cnt_next.sv
module gpt_cnt_next
    import gpt_pkg::*;
(
    input  logic              run,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              oneshot,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  load,
    input  logic [CNT_W-1:0]  match,
    input  logic              tick,
    output logic [CNT_W-1:0]  cnt_nxt,
    output logic              run_nxt,
    output logic              ev_timeout,
    output logic              ev_rtc
);
    logic [CNT_W-1:0] cnt_inc;
    assign cnt_inc = cnt + CNT_W'(1);

    always_comb begin
        cnt_nxt    = cnt;
        run_nxt    = run;
        ev_timeout = 1'b0;
        ev_rtc     = 1'b0;
        if (run && cfg == CFG_CHAIN) begin
            if (cnt == '0) begin
                ev_timeout = 1'b1;
                cnt_nxt    = load;
                if (oneshot) run_nxt = 1'b0;
            end else begin
                cnt_nxt = cnt - CNT_W'(1);
            end
        end else if (run && cfg == CFG_RTC && tick) begin
            cnt_nxt = cnt_inc;
            ev_rtc  = (cnt_inc == match);
        end
    end
endmodule

// File: rtl/gpt_rmux.sv
module gpt_rmux
    import gpt_pkg::*;
(
    input  gpt_state_t        st,
    input  logic [NREG-1:0]   hit,
    output logic [DATA_W-1:0] rdata
);
    logic joined;
    assign joined = (st.cfg < CFG_SPLIT_MIN);

    always_comb begin
        rdata = '0;
        if (hit[RI_CFG])     rdata = DATA_W'(st.cfg);
        if (hit[RI_MODE_A])  rdata = DATA_W'(st.mode_a);
        if (hit[RI_MODE_B])  rdata = DATA_W'(st.mode_b);
        if (hit[RI_CTL])     rdata = DATA_W'(st.ctl);
        if (hit[RI_MASK])    rdata = DATA_W'(st.mask);
        if (hit[RI_RAW])     rdata = DATA_W'(st.raw);
        if (hit[RI_MIS])     rdata = DATA_W'(st.raw & st.mask);
        if (hit[RI_LOAD_A])  rdata = {joined ? st.load_hi : '0, st.load_lo};
        if (hit[RI_LOAD_B])  rdata = DATA_W'(st.load_hi);
        if (hit[RI_MATCH_A]) rdata = {joined ? st.match_hi : '0, st.match_lo};
        if (hit[RI_MATCH_B]) rdata = DATA_W'(st.match_hi);
        if (hit[RI_PRE_A])   rdata = DATA_W'(st.pre_a);
        if (hit[RI_PRE_B])   rdata = DATA_W'(st.pre_b);
        if (hit[RI_PMAT_A])  rdata = DATA_W'(st.pmat_a);
        if (hit[RI_PMAT_B])  rdata = DATA_W'(st.pmat_b);
        if (hit[RI_COUNT])   rdata = st.cnt;
    end
endmodule

// File: rtl/gpt_top.sv
module gpt_top
    import gpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sec_tick,
    output logic              irq,
    output logic              adc_trig
);
    gpt_state_t       st_q, st_d;
    logic [NREG-1:0]  hit, wstb;
    logic [CNT_W-1:0] cnt_nxt, load_full;
    logic             run_nxt, ev_timeout, ev_rtc;
    logic [IRQ_W-1:0] ev_bits, clr_bits;

    assign load_full = {st_q.load_hi, st_q.load_lo};

    gpt_wdec u_wdec (
        .wr   (bus_wr),
        .addr (bus_addr),
        .hit  (hit),
        .wstb (wstb)
    );

    gpt_cnt_next u_cnt (
        .run        (st_q.run),
        .cfg        (st_q.cfg),
        .oneshot    (st_q.mode_a[ONESHOT_BIT]),
        .cnt        (st_q.cnt),
        .load       (load_full),
        .match      ({st_q.match_hi, st_q.match_lo}),
        .tick       (sec_tick),
        .cnt_nxt    (cnt_nxt),
        .run_nxt    (run_nxt),
        .ev_timeout (ev_timeout),
        .ev_rtc     (ev_rtc)
    );

    gpt_rmux u_rmux (
        .st    (st_q),
        .hit   (hit),
        .rdata (bus_rdata)
    );

    always_comb begin
        ev_bits          = '0;
        ev_bits[TO_BIT]  = ev_timeout;
        ev_bits[RTC_BIT] = ev_rtc;
        clr_bits         = wstb[RI_CLR] ? bus_wdata[IRQ_W-1:0] : '0;
    end

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = cnt_nxt;
        st_d.run  = run_nxt;
        st_d.trig = ev_timeout & st_q.ctl[TRIG_BIT];
        st_d.raw  = (st_q.raw & ~clr_bits) | ev_bits;

        if (wstb[RI_CFG])    st_d.cfg    = bus_wdata[CFG_W-1:0];
        if (wstb[RI_MODE_A]) st_d.mode_a = bus_wdata[MODE_W-1:0];
        if (wstb[RI_MODE_B]) st_d.mode_b = bus_wdata[MODE_W-1:0];
        if (wstb[RI_MASK])   st_d.mask   = bus_wdata[IRQ_W-1:0] & MASK_KEEP;
        if (wstb[RI_PRE_A])  st_d.pre_a  = bus_wdata[PRE_W-1:0];
        if (wstb[RI_PRE_B])  st_d.pre_b  = bus_wdata[PRE_W-1:0];
        if (wstb[RI_PMAT_A]) st_d.pmat_a = bus_wdata[PRE_W-1:0];
        if (wstb[RI_PMAT_B]) st_d.pmat_b = bus_wdata[PRE_W-1:0];
        if (wstb[RI_LOAD_A]) begin
            st_d.load_lo = bus_wdata[HALF_W-1:0];
            st_d.load_hi = bus_wdata[DATA_W-1:HALF_W];
        end
        if (wstb[RI_LOAD_B]) st_d.load_hi = bus_wdata[HALF_W-1:0];
        if (wstb[RI_MATCH_A]) begin
            st_d.match_lo = bus_wdata[HALF_W-1:0];
            st_d.match_hi = bus_wdata[DATA_W-1:HALF_W];
        end
        if (wstb[RI_MATCH_B]) st_d.match_hi = bus_wdata[DATA_W-1:HALF_W];

        if (wstb[RI_CTL]) begin
            st_d.ctl = bus_wdata[CTL_W-1:0];
            if (bus_wdata[EN_A_BIT] != st_q.ctl[EN_A_BIT]) begin
                st_d.run = bus_wdata[EN_A_BIT];
                if (bus_wdata[EN_A_BIT])
                    st_d.cnt = (st_q.cfg == CFG_RTC) ? '0 : load_full;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq      = |(st_q.raw & st_q.mask);
    assign adc_trig = st_q.trig;
endmodule

// File: rtl/gpt_chk.sv
module gpt_chk
    import gpt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              adc_trig,
    input logic              sec_tick,
    input logic              run,
    input logic [CFG_W-1:0]  cfg,
    input logic              oneshot,
    input logic              ctl_trig,
    input logic [CNT_W-1:0]  cnt,
    input logic              raw_to
);
    logic ctl_wr;
    assign ctl_wr = bus_wr && (bus_addr == reg_off(RI_CTL));

    // R7
    mis_pin_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == reg_off(RI_MIS)) |-> (irq == (bus_rdata != '0)));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cfg == CFG_CHAIN && cnt != '0 && !ctl_wr) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R2
    expiry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cfg == CFG_CHAIN && cnt == '0) |=> raw_to);

    // R3
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cfg == CFG_CHAIN && cnt == '0 && oneshot && !ctl_wr) |=> !run);

    // R4
    trig_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> $past(run && cfg == CFG_CHAIN && cnt == '0 && ctl_trig));

    // R6
    rtc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cfg == CFG_RTC && !sec_tick && !ctl_wr) |=> $stable(cnt));
endmodule

bind gpt_top gpt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .adc_trig  (adc_trig),
    .sec_tick  (sec_tick),
    .run       (st_q.run),
    .cfg       (st_q.cfg),
    .oneshot   (st_q.mode_a[0]),
    .ctl_trig  (st_q.ctl[5]),
    .cnt       (st_q.cnt),
    .raw_to    (st_q.raw[0])
);

// File: tb/gpt_top_test.sv
`timescale 1ns/1ps
module gpt_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_tick = 1'b0;
    logic        irq, adc_trig;

    int    vectors = 0;
    int    misses = 0;
    string cur = "R1";

    always #2.5 clk = ~clk;

    gpt_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
        .irq(irq), .adc_trig(adc_trig)
    );

    // behavioural reference state
    bit [2:0]  m_cfg;
    bit [3:0]  m_ma, m_mb;
    bit [15:0] m_ctl, m_llo, m_lhi, m_mlo, m_mhi;
    bit [6:0]  m_mask, m_raw;
    bit [7:0]  m_pa, m_pb, m_qa, m_qb;
    bit [31:0] m_cnt;
    bit        m_run, m_trig;

    function automatic bit [31:0] exp_read(bit [11:0] a);
        case (a)
            12'h000: return 32'(m_cfg);
            12'h004: return 32'(m_ma);
            12'h008: return 32'(m_mb);
            12'h00C: return 32'(m_ctl);
            12'h018: return 32'(m_mask);
            12'h01C: return 32'(m_raw);
            12'h020: return 32'(m_raw & m_mask);
            12'h028: return (m_cfg < 4) ? {m_lhi, m_llo} : {16'h0, m_llo};
            12'h02C: return 32'(m_lhi);
            12'h030: return (m_cfg < 4) ? {m_mhi, m_mlo} : {16'h0, m_mlo};
            12'h034: return 32'(m_mhi);
            12'h038: return 32'(m_pa);
            12'h03C: return 32'(m_pb);
            12'h040: return 32'(m_qa);
            12'h044: return 32'(m_qb);
            12'h048: return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_step(bit wr, bit [11:0] a, bit [31:0] d, bit tk);
        bit [31:0] ld = {m_lhi, m_llo};
        bit [31:0] n_cnt = m_cnt;
        bit n_run = m_run;
        bit n_trig = 1'b0;
        bit [6:0] n_raw = m_raw;
        bit to = 1'b0, rt = 1'b0;
        if (m_run && m_cfg == 0) begin
            if (m_cnt == 0) begin
                to = 1'b1; n_trig = m_ctl[5]; n_cnt = ld;
                if (m_ma[0]) n_run = 1'b0;
            end else n_cnt = m_cnt - 1;
        end else if (m_run && m_cfg == 1 && tk) begin
            n_cnt = m_cnt + 1;
            if (n_cnt == {m_mhi, m_mlo}) rt = 1'b1;
        end
        if (wr && a == 12'h024) n_raw = n_raw & ~d[6:0];
        if (to) n_raw[0] = 1'b1;
        if (rt) n_raw[3] = 1'b1;
        if (wr) begin
            case (a)
                12'h000: m_cfg = d[2:0];
                12'h004: m_ma = d[3:0];
                12'h008: m_mb = d[3:0];
                12'h00C: begin
                    if (d[0] != m_ctl[0]) begin
                        n_run = d[0];
                        if (d[0]) n_cnt = (m_cfg == 1) ? 32'h0 : ld;
                    end
                    m_ctl = d[15:0];
                end
                12'h018: m_mask = d[6:0] & 7'h77;
                12'h028: begin m_llo = d[15:0]; m_lhi = d[31:16]; end
                12'h02C: m_lhi = d[15:0];
                12'h030: begin m_mlo = d[15:0]; m_mhi = d[31:16]; end
                12'h034: m_mhi = d[31:16];
                12'h038: m_pa = d[7:0];
                12'h03C: m_pb = d[7:0];
                12'h040: m_qa = d[7:0];
                12'h044: m_qb = d[7:0];
                default: ;
            endcase
        end
        m_cnt = n_cnt; m_run = n_run; m_trig = n_trig; m_raw = n_raw;
    endtask

    // one clock: drive at the falling edge, compare, advance the model
    task automatic cyc(bit wr, bit [11:0] a, bit [31:0] d, bit tk);
        bit [31:0] er;
        bit ei;
        bus_wr = wr; bus_addr = a; bus_wdata = d; sec_tick = tk;
        #1;
        er = exp_read(a);
        ei = |(m_raw & m_mask);
        vectors++;
        if (bus_rdata !== er || irq !== ei || adc_trig !== m_trig) begin
            misses++;
            $display("FAIL %s t=%0t addr=%h rdata=%h exp=%h irq=%b exp=%b trig=%b exp=%b",
                     cur, $time, a, bus_rdata, er, irq, ei, adc_trig, m_trig);
        end
        model_step(wr, a, d, tk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(bit [11:0] a, bit [31:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic watch(bit [11:0] a, int n);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        misses++;
        $display("FAIL watchdog expired in %s", cur);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur = "R1";
        for (int i = 0; i < 20; i++) cyc(1'b0, 12'(i * 4), 32'h0, 1'b0);

        cur = "R9";
        wr(12'h028, 32'hABCD1234);
        watch(12'h028, 1); watch(12'h02C, 1);
        wr(12'h000, 32'h4);
        watch(12'h028, 1);
        wr(12'h02C, 32'h5555_0077);
        watch(12'h02C, 1); watch(12'h028, 1);
        wr(12'h000, 32'h0);
        watch(12'h028, 1);

        cur = "R10";
        wr(12'h030, 32'h1234_5678);
        watch(12'h030, 1);
        wr(12'h034, 32'h9ABC_0011);
        watch(12'h034, 1); watch(12'h030, 1);
        wr(12'h000, 32'h7);
        watch(12'h030, 1);
        wr(12'h000, 32'h0);

        cur = "R11";
        wr(12'h038, 32'h1FF); wr(12'h03C, 32'h2A5);
        wr(12'h040, 32'hF0F); wr(12'h044, 32'h133);
        wr(12'h008, 32'hFF);
        for (int i = 0; i < 5; i++) watch(12'h038 + 12'(i * 4), 1);
        watch(12'h008, 1); watch(12'h100, 1); watch(12'h010, 1);

        cur = "R7";
        wr(12'h018, 32'hFFFF_FFFF);
        watch(12'h018, 1);

        cur = "R2";
        wr(12'h028, 32'h0000_0005);
        wr(12'h00C, 32'h21);
        watch(12'h048, 20);
        cur = "R4";
        watch(12'h020, 8);

        cur = "R8";
        wr(12'h024, 32'h1);
        watch(12'h01C, 2);
        wr(12'h024, 32'h1);
        watch(12'h01C, 6);

        cur = "R5";
        wr(12'h00C, 32'h21);
        watch(12'h048, 4);
        wr(12'h00C, 32'h20);
        watch(12'h048, 6);
        wr(12'h00C, 32'h01);
        watch(12'h048, 9);

        cur = "R8";
        wr(12'h00C, 32'h00);
        wr(12'h028, 32'h0);
        wr(12'h00C, 32'h21);
        watch(12'h01C, 2);
        wr(12'h024, 32'h7F);
        watch(12'h01C, 3);

        cur = "R3";
        wr(12'h00C, 32'h00);
        wr(12'h024, 32'h7F);
        wr(12'h004, 32'h1);
        wr(12'h028, 32'h0000_0003);
        wr(12'h00C, 32'h21);
        watch(12'h048, 12);
        watch(12'h01C, 2);

        cur = "R2";
        wr(12'h00C, 32'h00);
        wr(12'h004, 32'h0);
        wr(12'h028, 32'h0001_0002);
        wr(12'h00C, 32'h01);
        watch(12'h048, 6);

        cur = "R6";
        wr(12'h00C, 32'h00);
        wr(12'h024, 32'h7F);
        wr(12'h000, 32'h1);
        wr(12'h030, 32'h0000_0003);
        wr(12'h00C, 32'h01);
        for (int i = 0; i < 30; i++) cyc(1'b0, 12'h048, 32'h0, (i % 3) == 0);
        watch(12'h01C, 2);

        cur = "R7";
        wr(12'h018, 32'h0);
        watch(12'h020, 2);
        wr(12'h018, 32'h08);
        watch(12'h020, 2);
        wr(12'h024, 32'h08);
        watch(12'h020, 2);

        cur = "R5";
        wr(12'h00C, 32'h00);
        wr(12'h000, 32'h2);
        wr(12'h00C, 32'h01);
        watch(12'h048, 4);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule